// File: doc/BRIEF.md
# Two-Rank Serial Routing Configuration Register

This block holds the control state of a 32-source, 16-destination routing matrix. A frame of 193 bits is shifted in serially on the rising edges of `clk` while the chip select is low. The bits pass through to `sdo`, so several blocks can be chained into one long serial path. A level-sensitive second rank captures the shift contents while the update strobe is low, so every destination changes at once. While the strobe is high, the second rank keeps its old contents and a new frame can be shifted in behind it.

From the captured word, the block decodes the following for each destination: an enable flag, a 5-bit source index, and a one-hot source-select vector that is gated by the enable. It also produces a global clamp enable and a test-mode flag, which is raised when the mandatory zero padding holds a one. Each destination has an external pin that picks its overlay input in place of the matrix source. The block reports that choice only when the destination is enabled. The analog switches, buffers and clamps are outside the block; only their control words are produced here.

Top module: `xpt_cfg_reg`

## Requirements
- R1: `rst_n` low clears the shift rank and the second rank at once, with no clock edge needed. While it stays low, every enable, select, overlay pick, clamp, test-mode and `sdo` output is 0.
- R2: On a rising `clk` edge with `cs_n` low, `sdi` enters the shift rank. With `cs_n` high, no state changes.
- R3: `sdo` carries the bit that was shifted in 193 shifting edges earlier. Before 193 shifts have occurred since reset, it carries 0.
- R4: While `upd_n` is low, the decoded outputs follow the shift rank. While `upd_n` is high, they hold.
- R5: The frame order is fixed. The clamp bit is shifted first, then 96 pad bits, then one 6-bit field per destination from destination 15 down to destination 0. Each field is the enable first, followed by the index MSB first. `route_idx_o[k*5 +: 5]` and `route_en_o[k]` give destination k.
- R6: `src_sel_o[k*32 +: 32]` has bit j set exactly when destination k is enabled and its index is j. A disabled destination has all 32 bits zero, whatever its index.
- R7: `test_mode_o` is 1 when any captured pad bit is 1, and 0 otherwise.
- R8: `ovl_pick_o[k]` equals `ovl_sel_i[k]` when destination k is enabled, and 0 when it is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial shift clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Shift enable (chip select), active low |
| sdi | input | 1 | Serial data in |
| upd_n | input | 1 | Second-rank transparency strobe, active low |
| sdo | output | 1 | Serial data out for chaining |
| ovl_sel_i | input | 16 | Per-destination overlay select pins |
| route_en_o | output | 16 | Captured enable per destination |
| route_idx_o | output | 80 | Captured 5-bit source index per destination |
| src_sel_o | output | 512 | One-hot source select per destination |
| ovl_pick_o | output | 16 | Overlay chosen on an enabled destination |
| clamp_en_o | output | 1 | Global clamp enable |
| test_mode_o | output | 1 | A pad bit in the captured word is nonzero |

## Verification
The clocked properties sample `upd_n`, `cs_n`, `sdi` and `ovl_sel_i` only on rising `clk` edges. They therefore assume that these inputs change only between edges, and that a low pulse on `upd_n` spans at least one rising edge. Without that, a transparent window could open and close unseen. The stimulus drives every input on the falling edge and holds each update pulse for one or more whole cycles. Reset is always held across at least one rising edge, so the edge-sampled reference model sees it too.

// File: rtl/xpt_cfg_pkg.sv
package xpt_cfg_pkg;
  // Default geometry of the routing matrix.
  localparam int unsigned XPT_NUM_IN  = 32;
  localparam int unsigned XPT_NUM_OUT = 16;

  // Bits in one destination field: enable plus source index.
  function automatic int unsigned field_bits(input int unsigned num_in);
    return $clog2(num_in) + 1;
  endfunction

  // Total frame: clamp bit, zero pad as long as the fields, then the fields.
  function automatic int unsigned frame_bits(input int unsigned num_in,
                                             input int unsigned num_out);
    return 1 + 2 * num_out * field_bits(num_in);
  endfunction
endpackage

// File: rtl/xpt_shift_rank.sv
module xpt_shift_rank #(
  parameter int unsigned FRAME_W = 193
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sdi,
  output logic [FRAME_W-1:0] chain,
  output logic               sdo
);
  // New bits enter at bit 0; the oldest bit leaves from the top.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     chain <= '0;
    else if (!cs_n) chain <= {chain[FRAME_W-2:0], sdi};
  end

  assign sdo = chain[FRAME_W-1];

  // R2: a deselected edge leaves the rank untouched
  p_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(chain));

  // R2: a selected edge captures the serial input
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> chain[0] == $past(sdi));
endmodule

// File: rtl/xpt_hold_rank.sv
module xpt_hold_rank #(
  parameter int unsigned FRAME_W = 193
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_n,
  input  logic [FRAME_W-1:0] chain,
  output logic [FRAME_W-1:0] word
);
  // Level-sensitive second rank, cleared asynchronously.
  always_latch begin
    if (!rst_n)      word <= '0;
    else if (!upd_n) word <= chain;
  end

  // R4: strobe high across a whole cycle keeps the captured word
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_n && $past(upd_n)) |-> $stable(word));

  // R4: strobe low makes the second rank track the first
  p_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_n |-> word == chain);
endmodule

// File: rtl/xpt_frame_split.sv
module xpt_frame_split #(
  parameter int unsigned NUM_IN  = 32,
  parameter int unsigned NUM_OUT = 16
) (
  input  logic [1+2*NUM_OUT*($clog2(NUM_IN)+1)-1:0] word,
  output logic                                       clamp_en,
  output logic                                       pad_hit,
  output logic [NUM_OUT-1:0]                         en,
  output logic [NUM_OUT*$clog2(NUM_IN)-1:0]          idx
);
  localparam int unsigned IDX_W   = $clog2(NUM_IN);
  localparam int unsigned FIELD_W = IDX_W + 1;
  localparam int unsigned PAD_W   = NUM_OUT * FIELD_W;
  localparam int unsigned FRAME_W = 1 + PAD_W + NUM_OUT * FIELD_W;

  // First bit shifted ends up at the top of the word.
  assign clamp_en = word[FRAME_W-1];
  assign pad_hit  = |word[FRAME_W-2 -: PAD_W];

  // Destination 0 was shifted last, so its field sits at the bottom.
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_field
    assign en[k]                = word[k*FIELD_W + IDX_W];
    assign idx[k*IDX_W +: IDX_W] = word[k*FIELD_W +: IDX_W];
  end
endmodule

// File: rtl/xpt_route_dec.sv
module xpt_route_dec #(
  parameter int unsigned NUM_IN = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en_i,
  input  logic [$clog2(NUM_IN)-1:0] idx_i,
  input  logic                      ovl_sel_i,
  output logic [NUM_IN-1:0]         sel_o,
  output logic                      ovl_pick_o
);
  localparam int unsigned IDX_W = $clog2(NUM_IN);

  for (genvar j = 0; j < NUM_IN; j++) begin : g_src
    assign sel_o[j] = en_i && (idx_i == IDX_W'(j));
  end

  assign ovl_pick_o = en_i & ovl_sel_i;

  // R6: never more than one source on a destination
  p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> $onehot(sel_o));

  // R6: a disabled destination selects nothing
  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> sel_o == '0);

  // R8: overlay is reported only on an enabled destination
  p_pick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_pick_o |-> en_i);
endmodule

// File: rtl/xpt_cfg_reg.sv
module xpt_cfg_reg
  import xpt_cfg_pkg::*;
#(
  parameter int unsigned NUM_IN  = XPT_NUM_IN,
  parameter int unsigned NUM_OUT = XPT_NUM_OUT
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cs_n,
  input  logic                              sdi,
  input  logic                              upd_n,
  output logic                              sdo,
  input  logic [NUM_OUT-1:0]                ovl_sel_i,
  output logic [NUM_OUT-1:0]                route_en_o,
  output logic [NUM_OUT*$clog2(NUM_IN)-1:0] route_idx_o,
  output logic [NUM_OUT*NUM_IN-1:0]         src_sel_o,
  output logic [NUM_OUT-1:0]                ovl_pick_o,
  output logic                              clamp_en_o,
  output logic                              test_mode_o
);
  localparam int unsigned IDX_W   = $clog2(NUM_IN);
  localparam int unsigned FRAME_W = 1 + 2 * NUM_OUT * (IDX_W + 1);

  logic [FRAME_W-1:0] chain;
  logic [FRAME_W-1:0] word;

  xpt_shift_rank #(.FRAME_W(FRAME_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .sdi   (sdi),
    .chain (chain),
    .sdo   (sdo)
  );

  xpt_hold_rank #(.FRAME_W(FRAME_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .upd_n (upd_n),
    .chain (chain),
    .word  (word)
  );

  xpt_frame_split #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_split (
    .word     (word),
    .clamp_en (clamp_en_o),
    .pad_hit  (test_mode_o),
    .en       (route_en_o),
    .idx      (route_idx_o)
  );

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_dst
    xpt_route_dec #(.NUM_IN(NUM_IN)) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (route_en_o[k]),
      .idx_i      (route_idx_o[k*IDX_W +: IDX_W]),
      .ovl_sel_i  (ovl_sel_i[k]),
      .sel_o      (src_sel_o[k*NUM_IN +: NUM_IN]),
      .ovl_pick_o (ovl_pick_o[k])
    );
  end

  // R7: test mode can only appear while the second rank is open
  p_tmrise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_mode_o) |-> !upd_n);

  // R4: clamp enable moves only while the second rank is open
  p_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clamp_en_o) |-> !upd_n);
endmodule

// File: tb/test_xpt_cfg_reg.sv
module test_xpt_cfg_reg;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 32;
  localparam int NO = 16;
  localparam int IW = 5;
  localparam int FW = 6;
  localparam int PADW = NO * FW;
  localparam int FRAME = 1 + 2 * PADW;

  logic clk = 1'b0;
  logic rst_n, cs_n, sdi, upd_n, sdo;
  logic [NO-1:0]    ovl_sel_i;
  logic [NO-1:0]    route_en_o;
  logic [NO*IW-1:0] route_idx_o;
  logic [NO*NI-1:0] src_sel_o;
  logic [NO-1:0]    ovl_pick_o;
  logic clamp_en_o, test_mode_o;

  xpt_cfg_reg i_xpt_cfg_reg (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi), .upd_n(upd_n),
    .sdo(sdo), .ovl_sel_i(ovl_sel_i), .route_en_o(route_en_o),
    .route_idx_o(route_idx_o), .src_sel_o(src_sel_o),
    .ovl_pick_o(ovl_pick_o), .clamp_en_o(clamp_en_o),
    .test_mode_o(test_mode_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit mq[$];        // every bit shifted since reset, last FRAME kept; oldest first
  bit lat[FRAME];   // model of the second rank, in shift order
  bit fr[FRAME];    // frame under construction, in shift order

  task automatic chk(input string req, input logic [NO*NI-1:0] act,
                     input logic [NO*NI-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int fbase(input int k);
    return 1 + PADW + FW * (NO - 1 - k);
  endfunction

  task automatic compare_all();
    logic [NO-1:0]    e_en   = '0;
    logic [NO*IW-1:0] e_idx  = '0;
    logic [NO*NI-1:0] e_sel  = '0;
    logic [NO-1:0]    e_pick = '0;
    logic             e_tm   = 1'b0;
    for (int k = 0; k < NO; k++) begin
      int v = 0;
      for (int b = 1; b <= IW; b++) v = v * 2 + int'(lat[fbase(k) + b]);
      e_en[k] = lat[fbase(k)];
      e_idx[k*IW +: IW] = IW'(v);
      if (e_en[k]) begin
        e_sel[k*NI + v] = 1'b1;
        e_pick[k] = ovl_sel_i[k];
      end
    end
    for (int p = 1; p <= PADW; p++) e_tm = e_tm | lat[p];
    chk("R3 sdo", {511'b0, sdo}, {511'b0, mq[0]});
    chk("R5 enables", {496'b0, route_en_o}, {496'b0, e_en});
    chk("R5 indices", {432'b0, route_idx_o}, {432'b0, e_idx});
    chk("R5 clamp", {511'b0, clamp_en_o}, {511'b0, lat[0]});
    chk("R6 select", src_sel_o, e_sel);
    chk("R7 test mode", {511'b0, test_mode_o}, {511'b0, e_tm});
    chk("R8 overlay", {496'b0, ovl_pick_o}, {496'b0, e_pick});
  endtask

  // Reference model, stepped on every rising edge and compared 2 time units later.
  always begin
    @(posedge clk);
    if (!rst_n) begin
      mq = {};
      for (int i = 0; i < FRAME; i++) mq.push_back(1'b0);
      foreach (lat[i]) lat[i] = 1'b0;
    end else if (!cs_n) begin
      mq.push_back(sdi);
      void'(mq.pop_front());
    end
    #2;
    if (rst_n && !upd_n) foreach (lat[i]) lat[i] = mq[i];
    if (rst_n && !done) compare_all();
  end

  task automatic build(input bit clamp, input bit [PADW-1:0] pad,
                       input bit [NO-1:0] en, input int idx_of[NO]);
    fr[0] = clamp;
    for (int p = 0; p < PADW; p++) fr[1 + p] = pad[PADW-1-p];
    for (int k = NO - 1; k >= 0; k--) begin
      fr[fbase(k)] = en[k];
      for (int b = 0; b < IW; b++) fr[fbase(k) + 1 + b] = idx_of[k][IW-1-b];
    end
  endtask

  // gap > 0 inserts one deselected cycle with toggling data every gap bits (R2)
  task automatic send(input int gap);
    for (int i = 0; i < FRAME; i++) begin
      @(negedge clk);
      cs_n = 1'b0;
      sdi  = fr[i];
      if (gap > 0 && i % gap == gap - 1) begin
        @(negedge clk);
        cs_n = 1'b1;
        sdi  = ~fr[i];
      end
    end
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic pulse_update(input int n);
    @(negedge clk);
    upd_n = 1'b0;
    repeat (n) @(negedge clk);
    upd_n = 1'b1;
  endtask

  task automatic reset_state_check(input string tag);
    chk({tag, " enables"}, {496'b0, route_en_o}, '0);
    chk({tag, " select"}, src_sel_o, '0);
    chk({tag, " misc"}, {508'b0, sdo, clamp_en_o, test_mode_o, |ovl_pick_o}, '0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int ix[NO];
    rst_n = 1'b0; cs_n = 1'b1; upd_n = 1'b1; sdi = 1'b0; ovl_sel_i = '1;
    repeat (3) @(negedge clk);
    reset_state_check("R1 reset");
    rst_n = 1'b1;

    // Frame 1: mixed enables, loaded with strobe high (R4 hold), then opened.
    for (int k = 0; k < NO; k++) ix[k] = (k * 7 + 3) % NI;
    build(1'b1, '0, 16'b1011_0110_1101_1011, ix);
    send(0);
    repeat (4) @(negedge clk);
    ovl_sel_i = 16'hA5C3;
    pulse_update(2);

    // Frame 2: all enabled, nonzero pad (R7), shifted with deselected gaps (R2).
    for (int k = 0; k < NO; k++) ix[k] = NI - 1 - k;
    build(1'b0, 96'h0000_0100_0000_0000_0000_0001, '1, ix);
    send(17);
    pulse_update(1);
    ovl_sel_i = 16'h3C5A;

    // Frame 3: all disabled with maximum index (R6), shifted while transparent (R4).
    for (int k = 0; k < NO; k++) ix[k] = NI - 1;
    build(1'b1, '0, '0, ix);
    @(negedge clk);
    upd_n = 1'b0;
    send(0);
    @(negedge clk);
    upd_n = 1'b1;

    // Frame 4: index extremes 0 and 31, pad clean again.
    for (int k = 0; k < NO; k++) ix[k] = (k % 2 == 0) ? 0 : NI - 1;
    build(1'b0, '0, '1, ix);
    send(5);
    pulse_update(3);

    // Flush frame 4 out through sdo (R3).
    build(1'b0, '0, '0, ix);
    send(0);
    repeat (3) @(negedge clk);

    // Asynchronous reset between edges (R1).
    @(posedge clk);
    #3 rst_n = 1'b0;
    #1 reset_state_check("R1 async");
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // Frame 5 after reset.
    for (int k = 0; k < NO; k++) ix[k] = (k * 11) % NI;
    build(1'b1, '0, 16'h0FF0, ix);
    send(0);
    pulse_update(1);
    repeat (3) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule